// File: doc/BRIEF.md
# Float32 Special-Value Fixup Unit

This unit repairs a single IEEE-754 single-precision word after a numeric sequence has produced a result that is wrong for special inputs. The source word is sorted into one of eight classes: quiet NaN, signalling NaN, zero, exactly +1.0, -infinity, +infinity, other negative and other positive. The class number then selects a 4-bit action code from a 32-bit table word supplied with each operation.

The action code chooses the result. It can keep the prior destination word, pass the source unchanged, pass the source with its quiet bit set, or substitute one of several fixed constants. An 8-bit enable vector decides, per class, whether the operation raises a zero-divide flag, an invalid flag, or both.

An optional denormals-are-zero control replaces a source whose exponent field is zero with +0.0 before the source is classified. Results and flags are registered behind a valid strobe and appear one clock cycle later.

Top module: `fp32_fixup_unit`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge. When `in_valid` is low at the edge, `out_valid` is low after it.
- R2: The class index j is assigned in this priority order. Quiet NaN (exponent 0xFF, mantissa nonzero, mantissa bit 22 set) = 0. Signalling NaN (exponent 0xFF, mantissa nonzero, bit 22 clear) = 1. Either signed zero = 2. Exactly 0x3F800000 = 3. 0xFF800000 = 4. 0x7F800000 = 5. Any other value with sign bit 31 set = 6. Anything else = 7. Under this rule -1.0 falls in class 6.
- R3: The action code is bits [4j+3:4j] of `fix_table`.
- R4: Action 0 returns `prior_word`. Action 1 returns the source after any flush. Action 2 returns that source with bit 22 forced to one and every other bit kept.
- R5: Actions 3 to 15 return these words: 3 → 0xFFC00000; 4 → 0xFF800000; 5 → 0x7F800000; 6 → infinity with the sign of the flushed source; 7 → 0x80000000; 8 → 0x00000000; 9 → 0xBF800000; 10 → 0x3F800000; 11 → 0x3F000000; 12 → 0x42B40000; 13 → 0x3FC90FDB; 14 → 0x7F7FFFFF; 15 → 0xFF7FFFFF.
- R6: `flag_en` bits raise the flags as follows. Bit 0 raises divide-by-zero for class 2. Bit 1 raises invalid for class 2. Bit 2 raises divide-by-zero for class 3. Bit 3 raises invalid for class 3. Bit 4 raises invalid for class 1. Bit 5 raises invalid for class 4. Bit 6 raises invalid for class 6. Bit 7 raises invalid for class 5. No other combination raises a flag.
- R7: A single operation raises both flags together when both enables of its class are set.
- R8: With `daz` high, a source whose bits [30:23] are zero is treated as +0.0 (0x00000000) for classification and for actions 1, 2 and 6. With `daz` low, such a source is classified as an ordinary value of its sign. `prior_word` is never flushed.
- R9: While `in_valid` is low, `out_word`, `out_div0` and `out_inv` hold their last values.
- R10: After reset, `out_valid`, `out_word`, `out_div0` and `out_inv` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| prior_word | input | 32 | Prior destination word, returned by action 0 |
| src_word | input | 32 | Source word to classify |
| fix_table | input | 32 | Eight 4-bit action codes, indexed by class |
| flag_en | input | 8 | Per-class flag enables |
| daz | input | 1 | Flushes a source with a zero exponent field to +0.0 |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_word | output | 32 | Fixed-up result |
| out_div0 | output | 1 | Zero-divide flag |
| out_inv | output | 1 | Invalid flag |

## Verification
The assertions check four things on every cycle. The valid strobe follows `in_valid` with one cycle of latency. The outputs hold while no operation is presented. A keep action returns the prior word. The zero-divide flag stays low unless one of its two enables was set. The exact classification priority, the sixteen action encodings, the per-class flag routing and the flush behaviour are shown only by the bench's scenarios. These scenarios compare every class against every action code and every enable bit, using an independent reference model.

// File: rtl/fixup_pkg.sv
package fixup_pkg;
  localparam int WORD_W  = 32;
  localparam int CODE_W  = 4;
  localparam int N_CLASS = 8;
  localparam int CLS_W   = $clog2(N_CLASS);

  typedef enum logic [CLS_W-1:0] {
    CLS_QNAN = 3'd0, CLS_SNAN = 3'd1, CLS_ZERO = 3'd2, CLS_PONE = 3'd3,
    CLS_NINF = 3'd4, CLS_PINF = 3'd5, CLS_NEG  = 3'd6, CLS_POS  = 3'd7
  } cls_e;

  localparam logic [WORD_W-1:0] K_DEF_NAN = 32'hFFC0_0000;
  localparam logic [WORD_W-1:0] K_NINF    = 32'hFF80_0000;
  localparam logic [WORD_W-1:0] K_PINF    = 32'h7F80_0000;
  localparam logic [WORD_W-1:0] K_NZERO   = 32'h8000_0000;
  localparam logic [WORD_W-1:0] K_PZERO   = 32'h0000_0000;
  localparam logic [WORD_W-1:0] K_NONE    = 32'hBF80_0000;
  localparam logic [WORD_W-1:0] K_PONE    = 32'h3F80_0000;
  localparam logic [WORD_W-1:0] K_HALF    = 32'h3F00_0000;
  localparam logic [WORD_W-1:0] K_NINETY  = 32'h42B4_0000;
  localparam logic [WORD_W-1:0] K_HALFPI  = 32'h3FC9_0FDB;
  localparam logic [WORD_W-1:0] K_PMAX    = 32'h7F7F_FFFF;
  localparam logic [WORD_W-1:0] K_NMAX    = 32'hFF7F_FFFF;
endpackage

// File: rtl/fixup_classify.sv
module fixup_classify
  import fixup_pkg::*;
(
  input  logic [WORD_W-1:0] src,
  input  logic              daz,
  output logic [WORD_W-1:0] eff_src,
  output cls_e              cls
);
  localparam int EXP_LSB = 23;
  localparam int EXP_W   = 8;
  localparam int QBIT    = EXP_LSB - 1;

  logic [EXP_W-1:0]   exp_f;
  logic [EXP_LSB-1:0] man_f;

  always_comb begin
    eff_src = (daz && (src[WORD_W-2:EXP_LSB] == '0)) ? K_PZERO : src;
    exp_f   = eff_src[WORD_W-2:EXP_LSB];
    man_f   = eff_src[EXP_LSB-1:0];
    if (&exp_f && (man_f != '0))
      cls = eff_src[QBIT] ? CLS_QNAN : CLS_SNAN;
    else if ((exp_f == '0) && (man_f == '0))
      cls = CLS_ZERO;
    else if (eff_src == K_PONE)
      cls = CLS_PONE;
    else if (&exp_f)
      cls = eff_src[WORD_W-1] ? CLS_NINF : CLS_PINF;
    else
      cls = eff_src[WORD_W-1] ? CLS_NEG : CLS_POS;
  end
endmodule

// File: rtl/fixup_respond.sv
module fixup_respond
  import fixup_pkg::*;
(
  input  logic [WORD_W-1:0] prior,
  input  logic [WORD_W-1:0] eff_src,
  input  logic [WORD_W-1:0] table_w,
  input  cls_e              cls,
  output logic [CODE_W-1:0] act,
  output logic [WORD_W-1:0] result
);
  localparam int QBIT = 22;

  logic [CODE_W-1:0] codes [N_CLASS];

  for (genvar g = 0; g < N_CLASS; g++) begin : g_split
    assign codes[g] = table_w[g*CODE_W +: CODE_W];
  end

  assign act = codes[cls];

  always_comb begin
    unique case (act)
      4'd0:  result = prior;
      4'd1:  result = eff_src;
      4'd2:  begin
        result       = eff_src;
        result[QBIT] = 1'b1;
      end
      4'd3:  result = K_DEF_NAN;
      4'd4:  result = K_NINF;
      4'd5:  result = K_PINF;
      4'd6:  result = eff_src[WORD_W-1] ? K_NINF : K_PINF;
      4'd7:  result = K_NZERO;
      4'd8:  result = K_PZERO;
      4'd9:  result = K_NONE;
      4'd10: result = K_PONE;
      4'd11: result = K_HALF;
      4'd12: result = K_NINETY;
      4'd13: result = K_HALFPI;
      4'd14: result = K_PMAX;
      default: result = K_NMAX;
    endcase
  end
endmodule

// File: rtl/fixup_flags.sv
module fixup_flags
  import fixup_pkg::*;
(
  input  cls_e       cls,
  input  logic [7:0] en,
  output logic       div0,
  output logic       inv
);
  always_comb begin
    div0 = 1'b0;
    inv  = 1'b0;
    unique case (cls)
      CLS_ZERO: begin div0 = en[0]; inv = en[1]; end
      CLS_PONE: begin div0 = en[2]; inv = en[3]; end
      CLS_SNAN: inv = en[4];
      CLS_NINF: inv = en[5];
      CLS_NEG:  inv = en[6];
      CLS_PINF: inv = en[7];
      default:  ;
    endcase
  end
endmodule

// File: rtl/fp32_fixup_unit.sv
module fp32_fixup_unit
  import fixup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] prior_word,
  input  logic [WORD_W-1:0] src_word,
  input  logic [WORD_W-1:0] fix_table,
  input  logic [7:0]        flag_en,
  input  logic              daz,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_div0,
  output logic              out_inv
);
  logic [WORD_W-1:0] eff_src, res_c, word_nxt;
  logic [CODE_W-1:0] act_c;
  cls_e              cls_c;
  logic              div0_c, inv_c, div0_nxt, inv_nxt;

  fixup_classify u_cls (.src(src_word), .daz(daz), .eff_src(eff_src), .cls(cls_c));

  fixup_respond u_rsp (.prior(prior_word), .eff_src(eff_src), .table_w(fix_table),
                       .cls(cls_c), .act(act_c), .result(res_c));

  fixup_flags u_flg (.cls(cls_c), .en(flag_en), .div0(div0_c), .inv(inv_c));

  always_comb begin
    word_nxt = out_word;
    div0_nxt = out_div0;
    inv_nxt  = out_inv;
    if (in_valid) begin
      word_nxt = res_c;
      div0_nxt = div0_c;
      inv_nxt  = inv_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_div0  <= 1'b0;
      out_inv   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_word  <= word_nxt;
      out_div0  <= div0_nxt;
      out_inv   <= inv_nxt;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_word) && $stable(out_div0) && $stable(out_inv)));
  a_r4_keep_prior: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && act_c == 4'd0) |=> (out_word == $past(prior_word)));
  a_r6_div0_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flag_en[0] && !flag_en[2]) |=> !out_div0);
endmodule

// File: tb/tb_fp32_fixup_unit.sv
`timescale 1ns/1ps
module tb_fp32_fixup_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] prior_word = '0, src_word = '0, fix_table = '0;
  logic [7:0]  flag_en = '0;
  logic        daz = 1'b0;
  logic        out_valid, out_div0, out_inv;
  logic [31:0] out_word;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  fp32_fixup_unit dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .prior_word(prior_word), .src_word(src_word), .fix_table(fix_table),
    .flag_en(flag_en), .daz(daz), .out_valid(out_valid), .out_word(out_word),
    .out_div0(out_div0), .out_inv(out_inv));

  localparam logic [31:0] SAMPLES [8] = '{32'h7FC0_0001, 32'h7F80_0001, 32'h8000_0000,
    32'h3F80_0000, 32'hFF80_0000, 32'h7F80_0000, 32'hC040_0000, 32'h4049_0FDB};

  function automatic int ref_class(input logic [31:0] v);
    if (v[30:23] == 8'hFF && v[22:0] != 0) return v[22] ? 0 : 1;
    if (v[30:0] == 0) return 2;
    if (v == 32'h3F80_0000) return 3;
    if (v == 32'hFF80_0000) return 4;
    if (v == 32'h7F80_0000) return 5;
    return v[31] ? 6 : 7;
  endfunction

  function automatic logic [33:0] ref_model(input logic [31:0] p, s, t,
                                            input logic [7:0] e, input logic z);
    logic [31:0] x, w;
    logic [3:0]  a;
    logic        d, iv;
    int          c;
    x = (z && s[30:23] == 0) ? 32'h0 : s;
    c = ref_class(x);
    a = t[c*4 +: 4];
    case (a)
      0: w = p;             1: w = x;
      2: w = x | 32'h0040_0000;
      3: w = 32'hFFC0_0000; 4: w = 32'hFF80_0000;
      5: w = 32'h7F80_0000; 6: w = {x[31], 31'h7F80_0000};
      7: w = 32'h8000_0000; 8: w = 32'h0;
      9: w = 32'hBF80_0000; 10: w = 32'h3F80_0000;
      11: w = 32'h3F00_0000; 12: w = 32'h42B4_0000;
      13: w = 32'h3FC9_0FDB; 14: w = 32'h7F7F_FFFF;
      default: w = 32'hFF7F_FFFF;
    endcase
    d  = (c == 2 && e[0]) || (c == 3 && e[2]);
    iv = (c == 2 && e[1]) || (c == 3 && e[3]) || (c == 1 && e[4]) ||
         (c == 4 && e[5]) || (c == 6 && e[6]) || (c == 5 && e[7]);
    return {d, iv, w};
  endfunction

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] p, s, t,
                        input logic [7:0] e, input logic z);
    logic [33:0] exp;
    @(negedge clk);
    prior_word = p; src_word = s; fix_table = t; flag_en = e; daz = z; in_valid = 1'b1;
    exp = ref_model(p, s, t, e, z);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_div0, out_inv, out_word}, exp);
    check("R1 out_valid", {33'd0, out_valid}, 34'd1);
  endtask

  task automatic t_reset();
    check("R10 reset", {out_valid, out_div0, out_inv, out_word}, 35'd0);
  endtask

  task automatic t_actions();
    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 16; a++) begin
        logic [31:0] t;
        t = {8{~a[3:0]}};
        t[c*4 +: 4] = a[3:0];
        run_op("R2 R3 R4 R5 class/action", 32'h1234_5678, SAMPLES[c], t, 8'h00, 1'b0);
      end
    run_op("R2 -1.0 is class 6", 32'h0, 32'hBF80_0000, 32'h0A00_0000, 8'h00, 1'b0);
  endtask

  task automatic t_flags();
    for (int c = 0; c < 8; c++)
      for (int e = 0; e < 256; e++)
        run_op("R6 flag enables", 32'h0, SAMPLES[c], 32'h8888_8888, e[7:0], 1'b0);
  endtask

  task automatic t_both_flags();
    run_op("R7 zero raises both", 32'h0, 32'h0, 32'h1111_1111, 8'h03, 1'b0);
    run_op("R7 one raises both", 32'h0, 32'h3F80_0000, 32'h1111_1111, 8'h0C, 1'b0);
  endtask

  task automatic t_flush();
    run_op("R8 flush pos denorm to zero", 32'h0, 32'h0000_0001, 32'h0000_0100, 8'h01, 1'b1);
    run_op("R8 flush neg denorm sign drops", 32'h0, 32'h8000_0005, 32'h0000_0600, 8'h00, 1'b1);
    run_op("R8 no flush denorm is positive", 32'h0, 32'h0000_0001, 32'h1000_0000, 8'h01, 1'b0);
    run_op("R8 no flush neg denorm", 32'h0, 32'h8000_0005, 32'h0100_0000, 8'h40, 1'b0);
    run_op("R8 prior not flushed", 32'h0000_0003, 32'h0000_0001, 32'h0, 8'h00, 1'b1);
  endtask

  task automatic t_hold();
    logic [33:0] snap;
    run_op("R9 setup", 32'h0, 32'h0, 32'h0000_0D00, 8'h03, 1'b0);
    snap = {out_div0, out_inv, out_word};
    @(negedge clk);
    src_word = 32'h7F80_0001; fix_table = 32'h3333_3333; flag_en = 8'hFF;
    repeat (3) @(negedge clk);
    check("R9 hold while idle", {out_div0, out_inv, out_word}, snap);
    check("R1 idle valid low", {33'd0, out_valid}, 34'd0);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_actions();
    t_flags();
    t_both_flags();
    t_flush();
    t_hold();
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end
endmodule